// File: doc/BRIEF.md
# Resource-Shared Multicycle Complex Multiplier

This block forms the product of two complex numbers. Each operand arrives as one 32-bit word with a signed fixed-point real half and a signed fixed-point imaginary half. The result leaves as a word in the same layout. A full product needs four partial products. Here a single pair of multipliers is time-shared across two cycles and followed by one subtractor and one adder, so the operation takes three clock cycles. The arithmetic cost is about half that of a fully parallel datapath.

The caller presents both operands with a one-cycle `start` pulse while the block is idle. Three cycles later `done` pulses for one cycle and `product` carries the new result. `product` holds that value until the next accepted operation completes. The caller may issue the next `start` in the same cycle that `done` is high.

The controller has three named states. **IDLE** waits for work. On `start` it takes the transition *accept*: it latches the operands and multiplies the two direct terms (real×real and imag×imag) straight from the input ports. **CROSS** subtracts those two products to form the real half and multiplies the two cross terms. Its transition *advance* always leads to SUM. **SUM** adds the cross products to form the imaginary half and loads the output register. Its transition *finish* always returns to IDLE and raises `done` one cycle later.

Top module: `cmul_shared`

## Requirements
- R1: Every data word uses bits 31:16 for the real half and bits 15:0 for the imaginary half. Both halves are 16-bit two's complement with 15 fraction bits.
- R2: The real half of `product` equals bits 15:0 of (aRe·bRe − aIm·bIm) >>> 15. The difference is formed at full precision before the shift.
- R3: The imaginary half of `product` equals bits 15:0 of (aIm·bRe + aRe·bIm) >>> 15. The sum is formed at full precision before the shift.
- R4: Results outside the 16-bit range wrap and do not saturate. For example, (−1.0 + j0)·(−1.0 + j0) gives the word 0x80000000.
- R5: Rising edge n samples `start` high in IDLE. Then `done` is high after rising edge n+2, and `product` holds the new value at the same time.
- R6: `done` is never high for two consecutive cycles.
- R7: `product` changes only in the cycle in which `done` rises. Otherwise it holds its value.
- R8: A `start` sampled while the block is in CROSS or SUM is ignored. It produces no `done` and does not alter the result in progress.
- R9: While reset is asserted, and after it is released, `done` is 0 and `product` is 0 until the first operation completes.
- R10: A `start` sampled in the same cycle that `done` is high is accepted, which allows back-to-back operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request; operands are sampled with it |
| op_a | input | 32 | First complex operand (real 31:16, imag 15:0) |
| op_b | input | 32 | Second complex operand (same layout) |
| product | output | 32 | Registered complex product (same layout) |
| done | output | 1 | One-cycle pulse marking a new `product` |

## Verification
Each result is due a fixed two edges after the edge that samples `start`. The driver therefore stamps every expected item with the edge count of its start plus two. The monitor compares `product` and that stamp at the falling edge where `done` is seen. Between pulses the monitor checks that `product` has not moved. A `done` that arrives with no pending item, or in two consecutive cycles, is reported. This exposes both extra completions from an ignored `start` and stretched pulses.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CROSS = 2'd1,
        ST_SUM   = 2'd2
    } cmul_state_e;

    localparam int unsigned CMUL_HALF_W = 16;
    localparam int unsigned CMUL_FRAC   = 15;

endpackage

// File: rtl/cmul_ctrl.sv
module cmul_ctrl
    import cmul_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic capture,
    output logic cross_sel,
    output logic load_real,
    output logic load_result,
    output logic done
);

    cmul_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= (state_q == ST_SUM);
        end
    end

    always_comb begin
        state_d     = state_q;
        capture     = 1'b0;
        cross_sel   = 1'b0;
        load_real   = 1'b0;
        load_result = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    capture = 1'b1;
                    state_d = ST_CROSS;
                end
            end
            ST_CROSS: begin
                cross_sel = 1'b1;
                load_real = 1'b1;
                state_d   = ST_SUM;
            end
            ST_SUM: begin
                load_result = 1'b1;
                state_d     = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R5: an accepted start yields done after two further edges
    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q == ST_IDLE) |-> ##3 done);

    // R6: done lasts a single cycle
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a start while busy does not restart the sequence
    assert_busy_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CROSS && start) |=> (state_q == ST_SUM));

endmodule

// File: rtl/cmul_addsub.sv
module cmul_addsub #(
    parameter int unsigned IN_W     = 32,
    parameter bit          SUBTRACT = 1'b0
) (
    input  logic signed [IN_W-1:0] x,
    input  logic signed [IN_W-1:0] y,
    output logic signed [IN_W:0]   s
);

    logic signed [IN_W:0] xe, ye;

    always_comb begin
        xe = {x[IN_W-1], x};
        ye = {y[IN_W-1], y};
    end

    generate
        if (SUBTRACT) begin : g_sub
            always_comb s = xe - ye;
        end else begin : g_add
            always_comb s = xe + ye;
        end
    endgenerate

endmodule

// File: rtl/cmul_datapath.sv
module cmul_datapath #(
    parameter int unsigned HALF_W = 16,
    parameter int unsigned FRAC   = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture,
    input  logic                  cross_sel,
    input  logic                  load_real,
    input  logic                  load_result,
    input  logic [2*HALF_W-1:0]   a_in,
    input  logic [2*HALF_W-1:0]   b_in,
    output logic [2*HALF_W-1:0]   result
);

    localparam int unsigned WORD_W = 2 * HALF_W;
    localparam int unsigned PROD_W = 2 * HALF_W;
    localparam int unsigned ACC_W  = PROD_W + 1;
    localparam int unsigned N_MUL  = 2;

    logic [WORD_W-1:0] a_q, b_q;
    logic signed [HALF_W-1:0] mul_x [N_MUL];
    logic signed [HALF_W-1:0] mul_y [N_MUL];
    logic signed [PROD_W-1:0] prod_q [N_MUL];
    logic signed [ACC_W-1:0]  diff, sum;
    logic signed [ACC_W-1:0]  diff_sh, sum_sh;
    logic [HALF_W-1:0]        real_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (capture) begin
            a_q <= a_in;
            b_q <= b_in;
        end
    end

    // Multiplier operand steering: direct terms from ports, cross terms from latches
    always_comb begin
        if (cross_sel) begin
            mul_x[0] = $signed(a_q[HALF_W-1:0]);
            mul_y[0] = $signed(b_q[WORD_W-1:HALF_W]);
            mul_x[1] = $signed(a_q[WORD_W-1:HALF_W]);
            mul_y[1] = $signed(b_q[HALF_W-1:0]);
        end else begin
            mul_x[0] = $signed(a_in[WORD_W-1:HALF_W]);
            mul_y[0] = $signed(b_in[WORD_W-1:HALF_W]);
            mul_x[1] = $signed(a_in[HALF_W-1:0]);
            mul_y[1] = $signed(b_in[HALF_W-1:0]);
        end
    end

    genvar g;
    generate
        for (g = 0; g < N_MUL; g++) begin : g_mul
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    prod_q[g] <= '0;
                else if (capture || cross_sel)
                    prod_q[g] <= mul_x[g] * mul_y[g];
            end
        end
    endgenerate

    cmul_addsub #(.IN_W(PROD_W), .SUBTRACT(1'b1)) u_sub (
        .x(prod_q[0]), .y(prod_q[1]), .s(diff)
    );

    cmul_addsub #(.IN_W(PROD_W), .SUBTRACT(1'b0)) u_add (
        .x(prod_q[0]), .y(prod_q[1]), .s(sum)
    );

    always_comb begin
        diff_sh = diff >>> FRAC;
        sum_sh  = sum >>> FRAC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            real_q <= '0;
            result <= '0;
        end else begin
            if (load_real)
                real_q <= diff_sh[HALF_W-1:0];
            if (load_result)
                result <= {real_q, sum_sh[HALF_W-1:0]};
        end
    end

    // R8: latched operands move only when the controller accepts work
    assert_operands_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(a_q) && $stable(b_q)));

endmodule

// File: rtl/cmul_shared.sv
module cmul_shared #(
    parameter int unsigned HALF_W = cmul_pkg::CMUL_HALF_W,
    parameter int unsigned FRAC   = cmul_pkg::CMUL_FRAC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [2*HALF_W-1:0] op_a,
    input  logic [2*HALF_W-1:0] op_b,
    output logic [2*HALF_W-1:0] product,
    output logic                done
);

    localparam int unsigned WORD_W = 2 * HALF_W;

    logic capture, cross_sel, load_real, load_result;

    cmul_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .capture(capture), .cross_sel(cross_sel),
        .load_real(load_real), .load_result(load_result),
        .done(done)
    );

    cmul_datapath #(.HALF_W(HALF_W), .FRAC(FRAC)) u_dp (
        .clk(clk), .rst_n(rst_n),
        .capture(capture), .cross_sel(cross_sel),
        .load_real(load_real), .load_result(load_result),
        .a_in(op_a), .b_in(op_b), .result(product)
    );

    function automatic logic [HALF_W-1:0] ref_half(
        input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b, input bit want_imag);
        longint ar, ai, br, bi, acc;
        ar = longint'($signed(a[WORD_W-1:HALF_W]));
        ai = longint'($signed(a[HALF_W-1:0]));
        br = longint'($signed(b[WORD_W-1:HALF_W]));
        bi = longint'($signed(b[HALF_W-1:0]));
        acc = want_imag ? (ai * br + ar * bi) : (ar * br - ai * bi);
        acc = acc >>> FRAC;
        return acc[HALF_W-1:0];
    endfunction

    assert_real_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> product[WORD_W-1:HALF_W] == ref_half($past(op_a, 3), $past(op_b, 3), 1'b0));

    assert_imag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> product[HALF_W-1:0] == ref_half($past(op_a, 3), $past(op_b, 3), 1'b1));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(product));

endmodule

// File: tb/cmul_shared_tb_top.sv
module cmul_shared_tb_top;

    localparam int HALF_W = 16;
    localparam int WORD_W = 32;
    localparam int FRAC   = 15;

    typedef struct {
        logic [WORD_W-1:0] value;
        int                due;
        string             tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [WORD_W-1:0] op_a = '0, op_b = '0;
    logic [WORD_W-1:0] product;
    logic done;

    int checks = 0;
    int errors = 0;
    int edge_cnt = 0;
    bit finished = 0;
    exp_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    cmul_shared dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_a(op_a), .op_b(op_b), .product(product), .done(done)
    );

    function automatic logic [WORD_W-1:0] model(input logic [WORD_W-1:0] a,
                                                input logic [WORD_W-1:0] b);
        longint ar, ai, br, bi, re, im;
        logic [WORD_W-1:0] w;
        ar = longint'($signed(a[31:16])); ai = longint'($signed(a[15:0]));
        br = longint'($signed(b[31:16])); bi = longint'($signed(b[15:0]));
        re = (ar * br - ai * bi) >>> FRAC;
        im = (ai * br + ar * bi) >>> FRAC;
        w = {re[15:0], im[15:0]};
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [WORD_W-1:0] act,
                         input logic [WORD_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: called at a falling edge; pushes the expected item
    task automatic drive_op(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b,
                            input string tag);
        exp_t e;
        e.value = model(a, b);
        e.due   = edge_cnt + 3;
        e.tag   = tag;
        sb.push_back(e);
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (sb.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Monitor / scoreboard
    logic prev_done = 1'b0;
    logic [WORD_W-1:0] last_prod = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                check(!prev_done, "R6 done pulse width", {31'd0, prev_done}, '0);
                if (sb.size() == 0) begin
                    check(1'b0, "R8 unexpected done", product, '0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(product == e.value, e.tag, product, e.value);
                    check(edge_cnt == e.due, "R5 latency", edge_cnt, e.due);
                end
            end else begin
                check(product == last_prod, "R7 hold", product, last_prod);
            end
        end
        prev_done = done;
        last_prod = product;
    end

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R9 done in reset", {31'd0, done}, '0);
        check(product == '0, "R9 product in reset", product, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(product == '0 && done == 1'b0, "R9 after release", product, '0);

        // R1 R2 R3 mixed signs
        drive_op(32'h4000_2000, 32'h4000_E000, "R2 R3 basic");
        wait_idle();
        drive_op(32'hC000_7FFF, 32'h1234_8001, "R1 R2 R3 signed halves");
        wait_idle();
        drive_op(32'h0001_FFFF, 32'hFFFF_0001, "R2 R3 tiny truncation");
        wait_idle();

        // R4 wrap: (-1)*(-1) -> 0x8000 real
        drive_op(32'h8000_0000, 32'h8000_0000, "R4 wrap");
        wait_idle();
        check(product == 32'h8000_0000, "R4 wrap literal", product, 32'h8000_0000);
        drive_op(32'h8000_8000, 32'h8000_7FFF, "R4 wrap both");
        wait_idle();

        // R8: starts while busy are ignored
        drive_op(32'h2000_1000, 32'h3000_F000, "R8 first op kept");
        op_a = 32'h7FFF_7FFF; op_b = 32'h7FFF_7FFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        check(product == model(32'h2000_1000, 32'h3000_F000), "R8 result after busy start",
              product, model(32'h2000_1000, 32'h3000_F000));

        // R10: back-to-back, start issued in the done cycle
        drive_op(32'h1111_2222, 32'h3333_4444, "R10 first");
        while (!done) @(negedge clk);
        drive_op(32'hF00F_0FF0, 32'h5A5A_A5A5, "R10 second");
        while (!done) @(negedge clk);
        drive_op(32'h7FFF_8000, 32'h7FFF_8000, "R10 third");
        wait_idle();
        repeat (5) @(negedge clk);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule